// File: doc/BRIEF.md
# Split 64-bit Register Bank

This block holds a small set of 64-bit registers and lets a 32-bit bus read and write them without tearing. Each 64-bit register occupies two adjacent 32-bit words. The word at the register's base byte offset carries bits 63..32, and the word 4 bytes above carries bits 31..0. Writing the base word only fills a per-register staging word. Writing the word at +4 then loads the full register in one step, combining the staged word with the new data. Reading the base word returns the live upper half and, on the same edge, freezes the live lower half. A later read of +4 returns that frozen half, so a value that is changing still reads back as one consistent 64-bit sample.

Register 0 is a control register. Bit 31 of its lower word acts as a software-reset request: loading a 1 there produces a single-cycle pulse, and the stored bit stays 0. The remaining registers are free-running event counters. Each one adds its own per-cycle increment input, and a completed 64-bit bus write loads it with a new value. Read data is registered and appears one clock after the read strobe.

Top module: `split64_regbank`

## Requirements
- R1: Register k lives at byte offset 8*k. Its upper half (bits 63..32) is at 8*k and its lower half (bits 31..0) is at 8*k+4. Register 0 is control and registers 1..NUM_CNT are counters. Address bits 1..0 are ignored.
- R2: A write to offset 8*k stores the data in register k's staging word and leaves the register value unchanged.
- R3: A write to offset 8*k+4 loads register k with {staging word, write data} in a single update, visible after that clock edge.
- R4: A write to 8*k+4 alone is legal and uses whatever is staged; after reset the staging word is zero, so a single write loads a 32-bit value.
- R5: Each register has its own staging word, so writes to another register between the two halves do not disturb it.
- R6: A read of 8*k returns the upper half of the register's current value on bus_rdata one cycle later and freezes the lower half. A read of 8*k+4 returns the frozen lower half.
- R7: Counter c (register c+1) adds slice c of cnt_inc, INC_W bits wide, every cycle. A read of upper then lower gives the value from the upper read's cycle even though the counter keeps running.
- R8: A 64-bit write to a counter presets it. The increment of that same cycle is dropped.
- R9: Loading a 1 into bit 31 of register 0 raises soft_rst_pulse for exactly the one cycle after the write. That bit always reads 0 and is 0 on ctrl_value. ctrl_value shows the loaded control value.
- R10: Synchronous reset clears staging words, frozen halves, counters, the control register, bus_rdata and soft_rst_pulse.
- R11: Writes to offsets beyond the last register are ignored, and reads of them return 0.
- R12: bus_rdata holds its last value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, one cycle after bus_re |
| cnt_inc | input | NUM_CNT*INC_W | Per-cycle increment for each counter, counter c in slice c |
| ctrl_value | output | 64 | Current control register value |
| soft_rst_pulse | output | 1 | One-cycle software-reset request |

## Verification
The assertions assume that reset is held across at least one rising edge before any bus traffic. They also assume that the strobes and the address are known values when sampled, and that a read and a write may share a cycle only when the read needs the pre-write value. The stimulus meets these assumptions: every input changes on falling edges only, and reset is held for several cycles at the start. Each access is a single-cycle strobe, and the counter increments are held at known values between changes. The expected values come from a bench-side model of the staging, freeze and counting rules.

// File: rtl/split64_pkg.sv
package split64_pkg;
  localparam int WORD_W  = 32;
  localparam int SWR_BIT = 31;

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [2*WORD_W-1:0] dword_t;

  typedef struct packed {
    logic hit;
    logic wr_upper;
    logic wr_lower;
    logic rd_upper;
    logic rd_lower;
  } acc_t;
endpackage

// File: rtl/split64_decode.sv
module split64_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic               re,
  output logic [ADDR_W-4:0]  idx,
  output split64_pkg::acc_t  acc
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [1:0] unused_byte_lanes;
  logic       upper;
  logic       hit;

  assign unused_byte_lanes = addr[1:0];

  always_comb begin
    idx          = addr[ADDR_W-1:3];
    upper        = !addr[2];
    hit          = (idx <= LAST_IDX);
    acc.hit      = hit;
    acc.wr_upper = we && hit && upper;
    acc.wr_lower = we && hit && !upper;
    acc.rd_upper = re && hit && upper;
    acc.rd_lower = re && hit && !upper;
  end
endmodule

// File: rtl/split64_half_store.sv
module split64_half_store #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stage_we,
  input  logic [W-1:0] stage_din,
  input  logic         snap_we,
  input  logic [W-1:0] snap_din,
  output logic [W-1:0] stage_q,
  output logic [W-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      snap_q  <= '0;
    end else begin
      if (stage_we) stage_q <= stage_din;
      if (snap_we)  snap_q  <= snap_din;
    end
  end
endmodule

// File: rtl/split64_ctrl_reg.sv
module split64_ctrl_reg (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit,
  input  split64_pkg::dword_t  commit_val,
  output split64_pkg::dword_t  value,
  output logic                 swr_pulse
);
  import split64_pkg::*;

  dword_t masked;

  always_comb begin
    masked          = commit_val;
    masked[SWR_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value     <= '0;
      swr_pulse <= 1'b0;
    end else begin
      swr_pulse <= commit && commit_val[SWR_BIT];
      if (commit) value <= masked;
    end
  end
endmodule

// File: rtl/split64_event_cnt.sv
module split64_event_cnt #(
  parameter int INC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INC_W-1:0]     inc,
  input  logic                 preset,
  input  split64_pkg::dword_t  preset_val,
  output split64_pkg::dword_t  count
);
  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (preset) count <= preset_val;
    else             count <= count + 64'(inc);
  end
endmodule

// File: rtl/split64_regbank.sv
module split64_regbank #(
  parameter int ADDR_W  = 8,
  parameter int NUM_CNT = 3,
  parameter int INC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_CNT*INC_W-1:0] cnt_inc,
  output logic [63:0]              ctrl_value,
  output logic                     soft_rst_pulse
);
  import split64_pkg::*;

  localparam int NUM_REGS = NUM_CNT + 1;
  localparam int IDX_W    = ADDR_W - 3;

  logic [IDX_W-1:0]    acc_idx;
  acc_t                acc;
  word_t               stage_q    [NUM_REGS];
  word_t               snap_q     [NUM_REGS];
  dword_t              reg_val    [NUM_REGS];
  dword_t              commit_val [NUM_REGS];
  logic [NUM_REGS-1:0] commit;
  word_t               sel_upper;
  word_t               sel_snap;

  split64_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .addr (bus_addr),
    .we   (bus_we),
    .re   (bus_re),
    .idx  (acc_idx),
    .acc  (acc)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit_k;
    assign hit_k = (acc_idx == IDX_W'(k));

    split64_half_store #(.W(WORD_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .stage_we  (acc.wr_upper && hit_k),
      .stage_din (bus_wdata),
      .snap_we   (acc.rd_upper && hit_k),
      .snap_din  (reg_val[k][31:0]),
      .stage_q   (stage_q[k]),
      .snap_q    (snap_q[k])
    );

    assign commit[k]     = acc.wr_lower && hit_k;
    assign commit_val[k] = {stage_q[k], bus_wdata};
  end

  split64_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit[0]),
    .commit_val (commit_val[0]),
    .value      (reg_val[0]),
    .swr_pulse  (soft_rst_pulse)
  );

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    split64_event_cnt #(.INC_W(INC_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .inc        (cnt_inc[c*INC_W +: INC_W]),
      .preset     (commit[c+1]),
      .preset_val (commit_val[c+1]),
      .count      (reg_val[c+1])
    );
  end

  always_comb begin
    sel_upper = '0;
    sel_snap  = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (acc_idx == IDX_W'(k)) begin
        sel_upper = reg_val[k][63:32];
        sel_snap  = snap_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (!acc.hit)         bus_rdata <= '0;
      else if (acc.rd_upper) bus_rdata <= sel_upper;
      else                  bus_rdata <= sel_snap;
    end
  end

  assign ctrl_value = reg_val[0];
endmodule

// File: rtl/split64_regbank_chk.sv
module split64_regbank_chk #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic [63:0]       ctrl_value,
  input logic              soft_rst_pulse
);
  logic ctl_upper_addr;
  logic ctl_lower_addr;
  logic far_addr;

  assign ctl_upper_addr = (bus_addr[ADDR_W-1:2] == '0);
  assign ctl_lower_addr = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign far_addr       = (bus_addr[ADDR_W-1:3] > (ADDR_W-3)'(NUM_REGS - 1));

  AST_UPPER_WRITE_STAGES_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_we && ctl_upper_addr |=> ctrl_value == $past(ctrl_value)); // R2

  AST_LOWER_WRITE_COMMITS: assert property (@(posedge clk) disable iff (rst)
    bus_we && ctl_lower_addr |=> ctrl_value[30:0] == $past(bus_wdata[30:0])); // R3

  AST_SWR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> !ctrl_value[31] || !bus_we); // R9

  AST_SWR_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    soft_rst_pulse |-> $past(bus_we && ctl_lower_addr && bus_wdata[31])); // R9

  AST_FAR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_re && far_addr |=> bus_rdata == '0); // R11

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata)); // R12

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bus_rdata == '0 && ctrl_value == '0 && !soft_rst_pulse); // R10
endmodule

bind split64_regbank split64_regbank_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_CNT + 1)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_we         (bus_we),
  .bus_re         (bus_re),
  .bus_rdata      (bus_rdata),
  .ctrl_value     (ctrl_value),
  .soft_rst_pulse (soft_rst_pulse)
);

// File: tb/tb_split64_regbank.sv
`timescale 1ns/1ps
module tb_split64_regbank;
  localparam int ADDR_W   = 8;
  localparam int NUM_CNT  = 3;
  localparam int INC_W    = 8;
  localparam int NUM_REGS = NUM_CNT + 1;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [ADDR_W-1:0]        bus_addr = '0;
  logic [31:0]              bus_wdata = '0;
  logic                     bus_we = 1'b0;
  logic                     bus_re = 1'b0;
  logic [31:0]              bus_rdata;
  logic [NUM_CNT*INC_W-1:0] cnt_inc = '0;
  logic [63:0]              ctrl_value;
  logic                     soft_rst_pulse;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  split64_regbank #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .INC_W(INC_W)) dut (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_we         (bus_we),
    .bus_re         (bus_re),
    .bus_rdata      (bus_rdata),
    .cnt_inc        (cnt_inc),
    .ctrl_value     (ctrl_value),
    .soft_rst_pulse (soft_rst_pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Model built from the requirements: staging, freeze and counting rules
  logic [63:0] m_val   [NUM_REGS];
  logic [31:0] m_stage [NUM_REGS];
  logic [31:0] m_latch [NUM_REGS];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        m_val[k]   <= '0;
        m_stage[k] <= '0;
        m_latch[k] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CNT; c++)
        m_val[c+1] <= m_val[c+1] + 64'(cnt_inc[c*INC_W +: INC_W]);
      if (bus_we && int'(bus_addr[7:3]) < NUM_REGS) begin
        if (!bus_addr[2]) m_stage[bus_addr[7:3]] <= bus_wdata;
        else if (bus_addr[7:3] == 0)
          m_val[0] <= {m_stage[0], 1'b0, bus_wdata[30:0]};
        else
          m_val[bus_addr[7:3]] <= {m_stage[bus_addr[7:3]], bus_wdata};
      end
      if (bus_re && int'(bus_addr[7:3]) < NUM_REGS && !bus_addr[2])
        m_latch[bus_addr[7:3]] <= m_val[bus_addr[7:3]][31:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
    if (int'(a[7:3]) >= NUM_REGS) return '0;
    if (!a[2]) return m_val[a[7:3]][63:32];
    return m_latch[a[7:3]];
  endfunction

  // Scoreboard
  logic [31:0] q_exp [$];
  string       q_req [$];
  logic        re_q = 1'b0;

  always @(posedge clk) re_q <= bus_re && !rst;

  always @(negedge clk) begin
    if (re_q) begin
      if (q_exp.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL scoreboard: read result with no expected item, actual %h expected none", bus_rdata);
      end else begin
        check(q_req.pop_front(), 64'(bus_rdata), 64'(q_exp.pop_front()));
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string req);
    bus_addr = a;
    bus_re   = 1'b1;
    q_exp.push_back(exp_read(a));
    q_req.push_back(req);
    @(negedge clk);
    bus_re   = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cnt_inc = {8'h00, 8'h03, 8'h01};

    // R10: state after reset
    check("R10 rdata", 64'(bus_rdata), 64'h0);
    check("R10 ctrl_value", ctrl_value, 64'h0);
    check("R10 pulse", 64'(soft_rst_pulse), 64'h0);
    rd(8'h04, "R10 frozen half cleared");

    // R2: upper write only stages
    wr(8'h00, 32'hA5A5_0001);
    check("R2 no update on upper write", ctrl_value, 64'h0);

    // R3: lower write commits atomically
    wr(8'h04, 32'h0000_1234);
    check("R3 commit", ctrl_value, 64'hA5A5_0001_0000_1234);

    // R5: interleaved staging on another register
    wr(8'h00, 32'h1111_2222);
    wr(8'h08, 32'h0000_DEAD);
    check("R5 counter upper write leaves ctrl", ctrl_value, 64'hA5A5_0001_0000_1234);
    wr(8'h04, 32'h0000_0005);
    check("R5 staged word kept", ctrl_value, 64'h1111_2222_0000_0005);

    // R6: upper then lower read of control
    rd(8'h00, "R6 upper read");
    rd(8'h04, "R6 lower read");

    // R4: single lower write with zero staging, carry across halves (R7)
    cnt_inc = {8'h20, 8'h03, 8'h01};
    wr(8'h1C, 32'hFFFF_FFF0);
    rd(8'h18, "R4 upper after single write");
    rd(8'h1C, "R4 lower after single write");
    rd(8'h18, "R7 upper after carry");
    repeat (3) @(negedge clk);
    rd(8'h1C, "R7 frozen lower while counting");

    // R7: running counters read coherently
    rd(8'h08, "R7 cnt0 upper");
    repeat (2) @(negedge clk);
    rd(8'h0C, "R7 cnt0 lower");
    cnt_inc = {8'hFF, 8'hFF, 8'h07};
    rd(8'h10, "R7 cnt1 upper");
    rd(8'h14, "R7 cnt1 lower");

    // R8: preset drops same-cycle increment
    wr(8'h0C, 32'h0000_0100);
    rd(8'h08, "R8 preset upper");
    rd(8'h0C, "R8 preset lower");
    wr(8'h10, 32'h0000_0001);
    wr(8'h14, 32'hFFFF_FF00);
    rd(8'h10, "R8 cnt1 preset upper");
    rd(8'h14, "R8 cnt1 preset lower");

    // R1: byte-lane bits ignored
    rd(8'h0B, "R1 low address bits ignored");
    rd(8'h0E, "R1 low address bits ignored lower");

    // R9: software reset pulse
    wr(8'h04, 32'h8000_00FF);
    check("R9 pulse high", 64'(soft_rst_pulse), 64'h1);
    check("R9 bit31 cleared", ctrl_value, 64'h1111_2222_0000_00FF);
    @(negedge clk);
    check("R9 pulse single cycle", 64'(soft_rst_pulse), 64'h0);
    rd(8'h00, "R9 upper read");
    rd(8'h04, "R9 lower read bit31 zero");

    // R11: out of range
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF);
    check("R11 far write ignored", ctrl_value, 64'h1111_2222_0000_00FF);
    check("R11 no pulse from far write", 64'(soft_rst_pulse), 64'h0);
    rd(8'h40, "R11 far read");
    rd(8'h24, "R11 far read lower");

    // R12: rdata holds without reads
    held = exp_read(8'h00);
    rd(8'h00, "R12 read before idle");
    repeat (3) @(negedge clk);
    check("R12 rdata held", 64'(bus_rdata), 64'(held));

    repeat (2) @(negedge clk);
    if (q_exp.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q_exp.size());
    end
    finish_run();
  end
endmodule